// File: doc/BRIEF.md
# PATA PIO Host Cycle Engine

This block sits on a simple memory-mapped register bus and turns single register accesses into programmed-I/O cycles on a parallel ATA bus in True IDE mode. Software sets a control register, a configuration register and a PIO timing register. It then reaches the device's task-file registers and its 16-bit data register through shadow windows. A write to a window runs one bus write cycle. A read of a window runs one bus read cycle and stores the device's answer. Software then fetches that answer from a separate read-data register.

Every bus cycle has three phases: a setup phase with address and chip-select driven, an active phase with the read or write strobe low, and a recovery phase with the strobe high. Each phase length is programmed in controller clock cycles. When IORDY sampling is enabled, the device can stretch the active phase. The block holds no queue. While a cycle runs, a busy nibble in the status word is non-zero, and software polls it before it issues the next access. Device interrupts and cycle completion are collected in a write-one-to-clear status register, gated by a mask.

Top module: `pata_pio_host`

## Requirements
- R1: After reset, both strobes and both chip-selects are high, the data bus is not driven, `irq` is 0 and the status word (offset 0x80) reads 0.
- R2: Windows map as follows (offset → chip-select, device address): 0x54 data → CS0,0; 0x58 → CS0,1; 0x5C → CS0,2; 0x60 → CS0,3; 0x64 → CS0,4; 0x68 → CS0,5; 0x6C → CS0,6; 0x70 → CS0,7; 0x74 → CS1,6. A window write produces exactly one bus write cycle. Task-file writes put the low byte of the written word on the bus with the upper byte zero, and a chip-select is always asserted while a strobe is low.
- R3: The timing register (offset 0x10) holds setup in bits [3:0], active in bits [11:4] and recovery in bits [19:12]. Each phase lasts max(n,1) clock cycles, and the chip-select stays asserted from setup through recovery.
- R4: When configuration (offset 0x04) bit 1 is set and IORDY is low during the active phase, the active phase is extended and its count is frozen until IORDY is high. With the bit clear, IORDY is ignored.
- R5: Configuration bit 6 clear swaps the two bytes of the data window in both directions. Set, the bytes pass straight. Task-file windows are never swapped.
- R6: A window read runs a bus read cycle. The device data is captured at the end of the active phase and is returned at offset 0x7C: 16 bits for the data window, the low byte zero-extended for task-file windows.
- R7: While control register (offset 0x00) bit 0 is 0, window accesses start no bus cycle.
- R8: Status word bits [31:28] read 0xF from the cycle after an access is accepted until the bus cycle ends, and read 0 otherwise.
- R9: A window access that arrives while a cycle is in progress is dropped without effect.
- R10: Interrupt status (offset 0x08) bit 0 is set on a rising edge of the device interrupt and bit 1 on completion of a bus cycle. Writing 1 clears a bit, and a new event in the same cycle wins over the clear. `irq` is high when any status bit is set whose bit in the mask register (offset 0x0C) is 1.
- R11: Read and write strobes are never low together, and write data stays driven and unchanged from setup through the end of the active phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Register access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Masked interrupt request |
| ata_da | output | 3 | Device register address |
| ata_cs0_n | output | 1 | Command-block chip-select, active low |
| ata_cs1_n | output | 1 | Control-block chip-select, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data driven to the device |
| ata_dd_oe | output | 1 | Output enable for ata_dd_out |
| ata_dd_in | input | 16 | Data from the device |
| ata_iordy | input | 1 | Device ready, low to stretch a cycle |
| ata_intrq | input | 1 | Device interrupt request |

## Verification
An accepted access puts chip-select on the bus at the clock edge that registers it. The strobe falls max(setup,1) edges later and rises after max(active,1) plus any IORDY-low edges. The chip-select is released after a further max(recovery,1) edges, and on that same edge the busy nibble clears and the completion flag sets. The monitor counts these phases at falling clock edges, where each sample sees the value from the preceding rising edge. It compares the counts with the queued expectation only when the chip-select is released. Register reads are combinational and are sampled one time step after the address is applied. The read-data, status and interrupt checks are therefore made only after the bench has polled the busy nibble back to zero.

// File: rtl/pata_pio_host.sv
module pata_pio_host #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              irq,
  output logic [2:0]        ata_da,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [15:0]       ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [15:0]       ata_dd_in,
  input  logic              ata_iordy,
  input  logic              ata_intrq
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_IMR   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_WIN0  = ADDR_W'(8'h54);
  localparam logic [ADDR_W-1:0] A_WINN  = ADDR_W'(8'h74);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(8'h7C);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h80);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_REC} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               ctrl_en, cfg_iordy, cfg_straight;
  logic [1:0]         isr, imr;
  logic [19:0]        tim;
  logic [15:0]        rd_q;
  logic               cyc_wr, cyc_cs1, cyc_data;
  logic [2:0]         cyc_da;
  logic [15:0]        cyc_wd;
  logic               intrq_q;

  function automatic logic [15:0] order16(input logic [15:0] x, input logic straight);
    return straight ? x : {x[7:0], x[15:8]};
  endfunction

  logic [ADDR_W-1:0] win_off;
  logic [3:0]        win_idx;
  logic              win_hit, accept, last, done, intrq_rise, wr_isr;
  logic [31:0]       status_word;

  assign win_off    = host_addr - A_WIN0;
  assign win_idx    = win_off[5:2];
  assign win_hit    = host_addr >= A_WIN0 && host_addr <= A_WINN && host_addr[1:0] == 2'b00;
  assign accept     = host_sel && win_hit && ctrl_en && state == S_IDLE;
  assign last       = cnt <= CNT_W'(1);
  assign done       = state == S_REC && last;
  assign intrq_rise = ata_intrq && !intrq_q;
  assign wr_isr     = host_sel && host_we && host_addr == A_ISR;
  assign status_word = {(state != S_IDLE) ? 4'hF : 4'h0, 28'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      cyc_wr   <= 1'b0;
      cyc_cs1  <= 1'b0;
      cyc_data <= 1'b0;
      cyc_da   <= '0;
      cyc_wd   <= '0;
      rd_q     <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state    <= S_SETUP;
          cnt      <= CNT_W'(tim[3:0]);
          cyc_wr   <= host_we;
          cyc_cs1  <= win_idx == 4'd8;
          cyc_data <= win_idx == 4'd0;
          cyc_da   <= (win_idx == 4'd8) ? 3'd6 : win_idx[2:0];
          cyc_wd   <= (win_idx == 4'd0) ? order16(host_wdata[15:0], cfg_straight)
                                        : {8'h00, host_wdata[7:0]};
        end
        S_SETUP: if (last) begin
          state <= S_ACT;
          cnt   <= CNT_W'(tim[11:4]);
        end else cnt <= cnt - 1'b1;
        S_ACT: if (cfg_iordy && !ata_iordy) begin
          cnt <= cnt;
        end else if (last) begin
          state <= S_REC;
          cnt   <= CNT_W'(tim[19:12]);
          if (!cyc_wr)
            rd_q <= cyc_data ? order16(ata_dd_in, cfg_straight) : {8'h00, ata_dd_in[7:0]};
        end else cnt <= cnt - 1'b1;
        S_REC: if (last) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en      <= 1'b0;
      cfg_iordy    <= 1'b0;
      cfg_straight <= 1'b0;
      imr          <= '0;
      tim          <= '0;
      isr          <= '0;
      intrq_q      <= 1'b0;
    end else begin
      intrq_q <= ata_intrq;
      if (host_sel && host_we) begin
        if (host_addr == A_CTRL) ctrl_en <= host_wdata[0];
        if (host_addr == A_CFG) begin
          cfg_iordy    <= host_wdata[1];
          cfg_straight <= host_wdata[6];
        end
        if (host_addr == A_IMR)  imr <= host_wdata[1:0];
        if (host_addr == A_TIME) tim <= host_wdata[19:0];
      end
      isr <= (isr & ~(wr_isr ? host_wdata[1:0] : 2'b00)) | {done, intrq_rise};
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      A_CTRL:  host_rdata = {31'h0, ctrl_en};
      A_CFG:   host_rdata = {25'h0, cfg_straight, 4'h0, cfg_iordy, 1'b0};
      A_ISR:   host_rdata = {30'h0, isr};
      A_IMR:   host_rdata = {30'h0, imr};
      A_TIME:  host_rdata = {12'h0, tim};
      A_RDATA: host_rdata = {16'h0, rd_q};
      A_STAT:  host_rdata = status_word;
      default: host_rdata = '0;
    endcase
  end

  assign irq        = |(isr & imr);
  assign ata_da     = cyc_da;
  assign ata_cs0_n  = !(state != S_IDLE && !cyc_cs1);
  assign ata_cs1_n  = !(state != S_IDLE && cyc_cs1);
  assign ata_dior_n = !(state == S_ACT && !cyc_wr);
  assign ata_diow_n = !(state == S_ACT && cyc_wr);
  assign ata_dd_out = cyc_wd;
  assign ata_dd_oe  = cyc_wr && (state == S_SETUP || state == S_ACT);

  logic unused_ok;
  assign unused_ok = ^{host_wdata[31:20], win_off};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n)); // R11
  AST_CS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (ata_cs0_n != ata_cs1_n)); // R2
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !ctrl_en) |=> state == S_IDLE); // R7
  AST_IORDY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACT && cfg_iordy && !ata_iordy) |=> (state == S_ACT && $stable(cnt))); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && host_sel) |=> ($stable(cyc_da) && $stable(cyc_wr) && $stable(cyc_cs1))); // R9
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_isr && host_wdata[0] && !intrq_rise) |=> !isr[0]); // R10
  AST_BUSY_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> host_rdata[31:28] != 4'h0 || host_addr != A_STAT); // R8
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_diow_n && $past(!ata_diow_n)) |-> ($stable(ata_dd_out) && ata_dd_oe)); // R11
endmodule

// File: tb/sim_pata_pio_host.sv
`timescale 1ns/1ps
module sim_pata_pio_host;
  logic        clk = 0, rst_n = 0;
  logic        host_sel = 0, host_we = 0;
  logic [7:0]  host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        irq;
  logic [2:0]  ata_da;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = 16'h0;
  logic        ata_iordy = 1, ata_intrq = 0;

  always #2.5 clk = ~clk;

  pata_pio_host u0 (.clk, .rst_n, .host_sel, .host_we, .host_addr, .host_wdata,
    .host_rdata, .irq, .ata_da, .ata_cs0_n, .ata_cs1_n, .ata_dior_n, .ata_diow_n,
    .ata_dd_out, .ata_dd_oe, .ata_dd_in, .ata_iordy, .ata_intrq);

  int n_chk = 0, n_err = 0, n_cyc = 0;
  bit finished = 0;

  typedef struct {
    logic wr; logic cs1; logic [2:0] da; logic [15:0] data;
    int setup; int act; int rec; string req;
  } item_t;
  item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_cyc(input logic wr, input logic cs1, input logic [2:0] da,
                            input logic [15:0] data, input int s, input int a,
                            input int r, input string req);
    item_t it;
    it.wr = wr; it.cs1 = cs1; it.da = da; it.data = data;
    it.setup = s; it.act = a; it.rec = r; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: phases counted at falling edges, compared on chip-select release
  bit in_cyc = 0, hold_bad = 0, both_low = 0;
  int s_n = 0, a_n = 0, r_n = 0;
  logic m_wr, m_cs1; logic [2:0] m_da; logic [15:0] m_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ata_cs0_n || !ata_cs1_n) begin
        if (!in_cyc) begin
          in_cyc = 1; s_n = 0; a_n = 0; r_n = 0; hold_bad = 0; both_low = 0;
        end
        if (!ata_dior_n && !ata_diow_n) both_low = 1;
        if (!ata_dior_n || !ata_diow_n) begin
          if (a_n == 0) begin
            m_wr = !ata_diow_n; m_cs1 = !ata_cs1_n; m_da = ata_da; m_data = ata_dd_out;
          end else if (m_wr && ata_dd_out !== m_data) hold_bad = 1;
          if (m_wr && !ata_dd_oe) hold_bad = 1;
          a_n++;
        end else if (a_n == 0) begin
          s_n++;
          if (!ata_diow_n || (s_n > 0 && ata_dd_oe && ata_dd_out !== u_peek())) ;
        end else r_n++;
      end else if (in_cyc) begin
        in_cyc = 0;
        n_cyc++;
        chk(!both_low, "R11", "both strobes low", 1, 0);
        if (exp_q.size() == 0) chk(0, "R9", "unexpected bus cycle da", {29'h0, m_da}, 0);
        else begin
          item_t e;
          e = exp_q.pop_front();
          chk(m_wr == e.wr && m_cs1 == e.cs1 && m_da == e.da, e.req, "wr/cs1/da",
              {27'h0, m_wr, m_cs1, m_da}, {27'h0, e.wr, e.cs1, e.da});
          if (e.wr) begin
            chk(m_data == e.data, e.req, "write data", {16'h0, m_data}, {16'h0, e.data});
            chk(!hold_bad, "R11", "write data held", 1, 0);
          end
          chk(s_n == e.setup, e.req, "setup cycles", s_n, e.setup);
          chk(a_n == e.act, e.req, "active cycles", a_n, e.act);
          chk(r_n == e.rec, e.req, "recovery cycles", r_n, e.rec);
        end
      end
    end
  end

  function automatic logic [15:0] u_peek();
    return ata_dd_out;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_sel = 0; host_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); host_sel = 1; host_we = 0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk); host_sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 1000; i++) begin
      rd(8'h80, v);
      if (v[31:28] == 4'h0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c0;
    repeat (5) @(negedge clk);
    chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_dd_oe && !irq,
        "R1", "bus idle in reset", {26'h0, ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe, irq}, 32'h3C);
    rst_n = 1;
    @(negedge clk);
    chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_dd_oe && !irq,
        "R1", "bus idle after reset", {26'h0, ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe, irq}, 32'h3C);
    rd(8'h80, v); chk(v == 0, "R1", "status after reset", v, 0);

    wr(8'h00, 1); wr(8'h10, 32'h2053); wr(8'h04, 32'h40); wr(8'h0C, 0);

    // R2 task-file write, R3 programmed phases, R8 busy nibble
    expect_cyc(1, 0, 3'd4, 16'h00CD, 3, 5, 2, "R2");
    wr(8'h64, 32'hABCD);
    rd(8'h80, v); chk(v[31:28] == 4'hF, "R8", "busy nibble during cycle", v, 32'hF0000000);
    wait_idle();
    rd(8'h80, v); chk(v == 0, "R8", "busy nibble after cycle", v, 0);

    // R5 data window byte order
    expect_cyc(1, 0, 3'd0, 16'h1234, 3, 5, 2, "R5");
    wr(8'h54, 32'h1234); wait_idle();
    wr(8'h04, 0);
    expect_cyc(1, 0, 3'd0, 16'h3412, 3, 5, 2, "R5");
    wr(8'h54, 32'h1234); wait_idle();
    expect_cyc(1, 0, 3'd1, 16'h0012, 3, 5, 2, "R5");
    wr(8'h58, 32'h3412); wait_idle();

    // R2 control-block window
    expect_cyc(1, 1, 3'd6, 16'h0055, 3, 5, 2, "R2");
    wr(8'h74, 32'h55); wait_idle();

    // R3 zero counts give one cycle per phase
    wr(8'h10, 0);
    expect_cyc(1, 0, 3'd6, 16'h00E0, 1, 1, 1, "R3");
    wr(8'h6C, 32'hE0); wait_idle();
    wr(8'h10, 32'h2053);

    // R6 split-phase reads
    ata_dd_in = 16'hA55A;
    expect_cyc(0, 0, 3'd0, 0, 3, 5, 2, "R6");
    rd(8'h54, v); wait_idle();
    rd(8'h7C, v); chk(v == 32'h5AA5, "R6", "data read swapped", v, 32'h5AA5);
    wr(8'h04, 32'h40);
    expect_cyc(0, 0, 3'd0, 0, 3, 5, 2, "R6");
    rd(8'h54, v); wait_idle();
    rd(8'h7C, v); chk(v == 32'hA55A, "R6", "data read straight", v, 32'hA55A);
    ata_dd_in = 16'hC37E;
    expect_cyc(0, 0, 3'd2, 0, 3, 5, 2, "R6");
    rd(8'h5C, v); wait_idle();
    rd(8'h7C, v); chk(v == 32'h7E, "R6", "task-file read", v, 32'h7E);

    // R4 IORDY stretch: released 3 edges into the active phase
    wr(8'h04, 32'h42);
    ata_iordy = 0;
    expect_cyc(0, 0, 3'd7, 0, 3, 8, 2, "R4");
    rd(8'h70, v);
    do @(negedge clk); while (ata_dior_n);
    repeat (3) @(negedge clk);
    ata_iordy = 1;
    wait_idle();
    wr(8'h04, 32'h40);
    ata_iordy = 0;
    expect_cyc(0, 0, 3'd7, 0, 3, 5, 2, "R4");
    rd(8'h70, v); wait_idle();
    ata_iordy = 1;

    // R9 access during a cycle is dropped
    c0 = n_cyc;
    expect_cyc(1, 0, 3'd3, 16'h0011, 3, 5, 2, "R9");
    wr(8'h60, 32'h11);
    wr(8'h68, 32'h22);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_cyc == c0 + 1, "R9", "cycles after busy access", n_cyc, c0 + 1);

    // R7 disabled interface
    wr(8'h00, 0);
    c0 = n_cyc;
    wr(8'h70, 32'h20);
    rd(8'h80, v); chk(v == 0, "R7", "no busy while disabled", v, 0);
    repeat (30) @(negedge clk);
    chk(n_cyc == c0, "R7", "no cycle while disabled", n_cyc, c0);
    wr(8'h00, 1);

    // R10 interrupt status and mask
    wr(8'h08, 3);
    rd(8'h08, v); chk(v == 0, "R10", "status cleared", v, 0);
    @(negedge clk); ata_intrq = 1;
    repeat (2) @(negedge clk);
    rd(8'h08, v); chk(v == 1, "R10", "device edge latched", v, 1);
    chk(!irq, "R10", "masked irq", irq, 0);
    wr(8'h0C, 1);
    chk(irq, "R10", "unmasked irq", irq, 1);
    wr(8'h08, 1);
    rd(8'h08, v); chk(v == 0, "R10", "write-one clear", v, 0);
    chk(!irq, "R10", "irq after clear", irq, 0);
    ata_intrq = 0;
    wr(8'h0C, 2);
    expect_cyc(1, 0, 3'd1, 16'h0001, 3, 5, 2, "R10");
    wr(8'h58, 32'h1); wait_idle();
    rd(8'h08, v); chk(v == 2, "R10", "done flag", v, 2);
    chk(irq, "R10", "done irq", irq, 1);
    wr(8'h08, 2);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all expected cycles seen", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule